// File: doc/BRIEF.md
# SD Command Token Issue Unit

This unit sits between a register port and the command-line serialiser of an SD/MMC host. Software first writes a 32-bit argument, then a 16-bit command word. The command word holds the command index, the expected response type and the data-transfer flags. Writing the command word launches the command. The unit builds the complete 48-bit command token, including its CRC7, and presents it for one cycle to a shifter. At the same moment it tells the response receiver which response length to expect. It then holds a busy flag until that receiver reports a response or a timeout.

A separate stop-control write can do two things. It can emit a stop-transmission command (index 12, argument 0) at once. It can also arm an automatic stop, which is sent when the final block of the next multi-block data command completes. For that case the unit counts block-done pulses down from the block count captured at launch. When the last block finishes, it emits the stop token and pulses `auto_stop` once, then disarms.

Top module: `sdcmd_issue`

## Requirements
- R1: While `rst_n` is low, `tok`, `tok_vld`, `rsp_kind`, `busy` and `auto_stop` are all zero. Reset also clears the argument register, the arm flag and block tracking.
- R2: A command-word write that is accepted makes `tok_vld` high for exactly the following cycle. In that cycle `tok` = {bit47 = 0, bit46 = 1, bits 45:40 = command-word bits 5:0, bits 39:8 = argument, bits 7:1 = CRC7, bit0 = 1}. `tok` keeps its value until the next token.
- R3: The CRC7 is computed over token bits 47:8 (MSB first), with generator x^7+x^3+1 and an initial value of zero. Examples of the final token byte: index 0 with argument 0 gives 0x95; index 8 with argument 0x1AA gives 0x87; index 17 with argument 0 gives 0x55.
- R4: `rsp_kind` is set from command-word bits 10:8 and is valid with the token: value 3 gives 0 (no response), value 6 gives 2 (136-bit), and every other value gives 1 (48-bit). Stop tokens always carry `rsp_kind` 1.
- R5: `busy` rises one cycle after an accepted command write whose `rsp_kind` is nonzero. A no-response command leaves `busy` low. A `rsp_done` or `rsp_tmo` pulse clears `busy` one cycle later.
- R6: A command-word write while `busy` is high is ignored: no token appears and no state changes.
- R7: `reg_sel` chooses the target of a write: 0 is the argument (all 32 bits of `reg_wdata`), 1 is the command word (bits 15:0), 2 is stop control (bits 15:0), and 3 has no effect. Argument writes are taken even while busy. A command uses the argument held at the time of its write.
- R8: A stop-control write with bit 0 set emits, in the next cycle, a token with index 12 and argument 0. This does not change `busy`, cancels any block tracking in progress, and raises no `auto_stop`.
- R9: Every stop-control write loads the arm flag from bit 8. Writing bit 8 as 0 disarms the unit and cancels tracking. The write itself produces no token unless bit 0 is set.
- R10: A command launched while armed with bit 11 (data) and bit 13 (multi-block) set, and a nonzero `blk_count`, starts tracking that many blocks. One cycle after the `blk_done` pulse that finishes the last block, the unit emits an index-12 token with `auto_stop` high for one cycle and disarms.
- R11: `blk_done` has no effect when no tracking is in progress. A data command with bit 13 clear, or one launched while disarmed, starts no tracking and leaves the arm flag as it was.
- R12: When an automatic stop fires in the same cycle as a command-word write, only the stop token is emitted and the command write is ignored. A stop-control write in the same cycle as the final `blk_done` suppresses the automatic stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 arg, 1 command, 2 stop control) |
| reg_wdata | input | 32 | Write data |
| blk_count | input | BLK_W | Number of blocks, captured at a tracked launch |
| blk_done | input | 1 | One-cycle pulse per finished data block |
| rsp_done | input | 1 | Response receiver got the response |
| rsp_tmo | input | 1 | Response receiver timed out |
| tok | output | 48 | Command token for the serialiser |
| tok_vld | output | 1 | One-cycle strobe marking a new token |
| rsp_kind | output | 2 | Expected response: 0 none, 1 48-bit, 2 136-bit |
| busy | output | 1 | A command awaits its response |
| auto_stop | output | 1 | Pulse marking an automatically issued stop |

## Verification
Every result of this unit is registered once. The token, `tok_vld`, `rsp_kind` and `auto_stop` therefore follow the rising edge that samples a write or a final `blk_done`. `busy` rises or falls on that same edge after the write or the response pulse. The bench applies each stimulus for one cycle starting at a falling edge and judges the response at the next falling edge. There, a monitor pops the scoreboard entry that the driver queued for that stimulus, and direct checks on `busy`, `tok_vld` and `auto_stop` are made at the same point. A token that appears when nothing is queued, and any entry still queued at the end, both count as failures.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int IDX_W = 6;
    localparam int ARG_W = 32;
    localparam int CRC_W = 7;
    localparam int MSG_W = 2 + IDX_W + ARG_W;
    localparam int TOK_W = MSG_W + CRC_W + 1;
    localparam int WORD_W = 16;

    localparam logic [1:0] SEL_ARG  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_STOP = 2'd2;

    localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam logic [2:0] RTYPE_NONE = 3'd3;
    localparam logic [2:0] RTYPE_LONG = 3'd6;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2
    } rsp_kind_e;

    function automatic logic [CRC_W-1:0] crc7_calc(input logic [MSG_W-1:0] msg);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb = msg[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic rsp_kind_e kind_of(input logic [2:0] rtype);
        if (rtype == RTYPE_NONE)      return RSP_NONE;
        else if (rtype == RTYPE_LONG) return RSP_LONG;
        else                          return RSP_SHORT;
    endfunction

endpackage

// File: rtl/sdcmd_regdec.sv
module sdcmd_regdec
    import sdcmd_pkg::*;
(
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] word,
    output logic              arg_wr,
    output logic              cmd_wr,
    output logic              stop_wr,
    output logic [IDX_W-1:0]  c_idx,
    output logic [2:0]        c_rtype,
    output logic              c_data,
    output logic              c_multi,
    output logic              s_now,
    output logic              s_arm
);
    logic unused_word_bits;

    always_comb begin
        arg_wr  = we && (sel == SEL_ARG);
        cmd_wr  = we && (sel == SEL_CMD);
        stop_wr = we && (sel == SEL_STOP);
        c_idx   = word[5:0];
        c_rtype = word[10:8];
        c_data  = word[11];
        c_multi = word[13];
        s_now   = word[0];
        s_arm   = word[8];
    end

    // class, direction and security bits do not change the token
    assign unused_word_bits = ^{word[7:6], word[12], word[15:14]};

endmodule

// File: rtl/sdcmd_tokgen.sv
module sdcmd_tokgen
    import sdcmd_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic [TOK_W-1:0] tok
);
    logic [MSG_W-1:0] msg;
    logic [CRC_W-1:0] crc;

    always_comb begin
        msg = {2'b01, idx, arg};
        crc = crc7_calc(msg);
        tok = {msg, crc, 1'b1};
    end

endmodule

// File: rtl/sdcmd_stoptrk.sv
module sdcmd_stoptrk #(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_wr,
    input  logic             s_now,
    input  logic             s_arm,
    input  logic             launch_multi,
    input  logic [BLK_W-1:0] blk_count,
    input  logic             blk_done,
    output logic             fire
);
    localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

    typedef struct packed {
        logic             armed;
        logic             trk;
        logic [BLK_W-1:0] cnt;
    } trk_t;

    trk_t trk_q, trk_d;

    always_comb begin
        trk_d = trk_q;
        fire  = trk_q.armed && trk_q.trk && blk_done &&
                (trk_q.cnt == ONE) && !stop_wr;

        if (trk_q.trk && blk_done && !stop_wr && (trk_q.cnt != '0))
            trk_d.cnt = trk_q.cnt - ONE;

        if (fire) begin
            trk_d.armed = 1'b0;
            trk_d.trk   = 1'b0;
        end

        if (stop_wr) begin
            trk_d.armed = s_arm;
            if (s_now || !s_arm) trk_d.trk = 1'b0;
        end

        if (launch_multi && trk_q.armed && (blk_count != '0)) begin
            trk_d.trk = 1'b1;
            trk_d.cnt = blk_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
    import sdcmd_pkg::*;
#(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic [BLK_W-1:0] blk_count,
    input  logic             blk_done,
    input  logic             rsp_done,
    input  logic             rsp_tmo,
    output logic [47:0]      tok,
    output logic             tok_vld,
    output logic [1:0]       rsp_kind,
    output logic             busy,
    output logic             auto_stop
);
    typedef struct packed {
        logic [TOK_W-1:0] tok;
        logic             vld;
        rsp_kind_e        kind;
        logic             busy;
        logic             auto_s;
        logic [ARG_W-1:0] arg;
    } st_t;

    st_t st_q, st_d;

    logic             arg_wr, cmd_wr, stop_wr;
    logic [IDX_W-1:0] c_idx;
    logic [2:0]       c_rtype;
    logic             c_data, c_multi, s_now, s_arm;
    logic             fire, issue_stop, launch, launch_multi;
    logic [IDX_W-1:0] tg_idx;
    logic [ARG_W-1:0] tg_arg;
    logic [TOK_W-1:0] tg_tok;
    rsp_kind_e        new_kind;

    sdcmd_regdec u_dec (
        .we      (reg_we),
        .sel     (reg_sel),
        .word    (reg_wdata[WORD_W-1:0]),
        .arg_wr  (arg_wr),
        .cmd_wr  (cmd_wr),
        .stop_wr (stop_wr),
        .c_idx   (c_idx),
        .c_rtype (c_rtype),
        .c_data  (c_data),
        .c_multi (c_multi),
        .s_now   (s_now),
        .s_arm   (s_arm)
    );

    sdcmd_stoptrk #(.BLK_W(BLK_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_wr      (stop_wr),
        .s_now        (s_now),
        .s_arm        (s_arm),
        .launch_multi (launch_multi),
        .blk_count    (blk_count),
        .blk_done     (blk_done),
        .fire         (fire)
    );

    sdcmd_tokgen u_tok (
        .idx (tg_idx),
        .arg (tg_arg),
        .tok (tg_tok)
    );

    always_comb begin
        issue_stop   = (stop_wr && s_now) || fire;
        launch       = cmd_wr && !st_q.busy && !fire;
        launch_multi = launch && c_data && c_multi;
        tg_idx       = issue_stop ? STOP_IDX : c_idx;
        tg_arg       = issue_stop ? '0 : st_q.arg;
        new_kind     = kind_of(c_rtype);

        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.auto_s = fire;

        if (arg_wr) st_d.arg = reg_wdata;
        if (rsp_done || rsp_tmo) st_d.busy = 1'b0;

        if (issue_stop) begin
            st_d.tok  = tg_tok;
            st_d.vld  = 1'b1;
            st_d.kind = RSP_SHORT;
        end else if (launch) begin
            st_d.tok  = tg_tok;
            st_d.vld  = 1'b1;
            st_d.kind = new_kind;
            st_d.busy = (new_kind != RSP_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok       = st_q.tok;
    assign tok_vld   = st_q.vld;
    assign rsp_kind  = st_q.kind;
    assign busy      = st_q.busy;
    assign auto_stop = st_q.auto_s;

endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk
    import sdcmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        blk_done,
    input logic        rsp_done,
    input logic        rsp_tmo,
    input logic [47:0] tok,
    input logic        tok_vld,
    input logic [1:0]  rsp_kind,
    input logic        busy,
    input logic        auto_stop
);
    logic unused_chk;
    assign unused_chk = blk_done;

    assert_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vld |-> (tok[47:46] == 2'b01) && tok[0]);

    assert_kind_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vld |-> (rsp_kind != 2'd3));

    assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (rsp_done || rsp_tmo) |=> !busy);

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rsp_done && !rsp_tmo && reg_we && (reg_sel == SEL_CMD)
        |=> !tok_vld || auto_stop);

    assert_force_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_sel == SEL_STOP) && reg_wdata[0]
        |=> tok_vld && (tok[45:8] == {STOP_IDX, 32'd0}) && !auto_stop);

    assert_auto_token_R10: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop |-> tok_vld && (tok[45:40] == STOP_IDX));

    assert_auto_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop |=> !auto_stop);

endmodule

bind sdcmd_issue sdcmd_issue_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .blk_done  (blk_done),
    .rsp_done  (rsp_done),
    .rsp_tmo   (rsp_tmo),
    .tok       (tok),
    .tok_vld   (tok_vld),
    .rsp_kind  (rsp_kind),
    .busy      (busy),
    .auto_stop (auto_stop)
);

// File: tb/sdcmd_issue_tb.sv
module sdcmd_issue_tb;
    localparam int BLK_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_sel = '0;
    logic [31:0]      reg_wdata = '0;
    logic [BLK_W-1:0] blk_count = '0;
    logic             blk_done = 1'b0;
    logic             rsp_done = 1'b0;
    logic             rsp_tmo = 1'b0;
    logic [47:0]      tok;
    logic             tok_vld;
    logic [1:0]       rsp_kind;
    logic             busy;
    logic             auto_stop;

    always #10 clk = ~clk;

    sdcmd_issue #(.BLK_W(BLK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .blk_count(blk_count), .blk_done(blk_done),
        .rsp_done(rsp_done), .rsp_tmo(rsp_tmo), .tok(tok), .tok_vld(tok_vld),
        .rsp_kind(rsp_kind), .busy(busy), .auto_stop(auto_stop)
    );

    typedef struct packed {
        logic [47:0] tok;
        logic [1:0]  kind;
        logic        auto_s;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // remainder of long division by 0x89 (x^7+x^3+1)
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    function automatic logic [47:0] ref_tok(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] m;
        m = {2'b01, idx, arg};
        return {m, ref_crc(m), 1'b1};
    endfunction

    function automatic logic [1:0] ref_kind(input logic [2:0] t);
        if (t == 3'd3) return 2'd0;
        if (t == 3'd6) return 2'd2;
        return 2'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] idx, input logic [31:0] arg,
                        input logic [1:0] kind, input logic a, input string tag);
        exp_t e;
        e.tok = ref_tok(idx, arg);
        e.kind = kind;
        e.auto_s = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                        input logic bd, input logic rd, input logic rt);
        reg_we = we; reg_sel = sel; reg_wdata = d;
        blk_done = bd; rsp_done = rd; rsp_tmo = rt;
        @(negedge clk);
        reg_we = 1'b0; blk_done = 1'b0; rsp_done = 1'b0; rsp_tmo = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        step(1'b1, sel, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: compares every token against the scoreboard
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (tok_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected token", {16'd0, tok}, 64'd0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(tok == e.tok, t, "token", {16'd0, tok}, {16'd0, e.tok});
                    chk(rsp_kind == e.kind, t, "rsp_kind", 64'(rsp_kind), 64'(e.kind));
                    chk(auto_stop == e.auto_s, t, "auto_stop", 64'(auto_stop), 64'(e.auto_s));
                end
            end else if (auto_stop) begin
                chk(1'b0, "R10", "auto_stop without token", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tok == '0 && !tok_vld && rsp_kind == 2'd0 && !busy && !auto_stop, "R1",
            "reset outputs", {11'd0, tok_vld, busy, auto_stop, rsp_kind, tok}, 64'd0);
        rst_n = 1'b1;

        // R2/R3/R5: no-response command, index 0
        wr(2'd0, 32'd0);
        push(6'd0, 32'd0, 2'd0, 1'b0, "R2");
        wr(2'd1, 32'h0000_0300);
        chk(tok[7:0] == 8'h95, "R3", "crc byte idx0", 64'(tok[7:0]), 64'h95);
        chk(!busy, "R5", "busy after no-response cmd", 64'(busy), 64'd0);

        // R7: argument then command index 8, short response
        wr(2'd0, 32'h0000_01AA);
        push(6'd8, 32'h1AA, 2'd1, 1'b0, "R7");
        wr(2'd1, 32'h0000_0408);
        chk(tok[7:0] == 8'h87, "R3", "crc byte idx8", 64'(tok[7:0]), 64'h87);
        chk(busy, "R5", "busy after R1 cmd", 64'(busy), 64'd1);

        // R6: command while busy ignored; argument write still taken (R7)
        wr(2'd1, 32'h0000_0411);
        chk(!tok_vld, "R6", "token while busy", 64'(tok_vld), 64'd0);
        wr(2'd3, 32'h0000_0001);
        chk(!tok_vld, "R7", "select 3 no effect", 64'(tok_vld), 64'd0);
        wr(2'd0, 32'hDEAD_BEEF);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        chk(!busy, "R5", "busy after rsp_done", 64'(busy), 64'd0);

        // R4: long response, cleared by timeout
        push(6'd2, 32'hDEAD_BEEF, 2'd2, 1'b0, "R4");
        wr(2'd1, 32'h0000_0602);
        chk(rsp_kind == 2'd2, "R4", "long kind", 64'(rsp_kind), 64'd2);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        chk(!busy, "R5", "busy after rsp_tmo", 64'(busy), 64'd0);

        wr(2'd0, 32'd0);
        push(6'd17, 32'd0, 2'd1, 1'b0, "R3");
        wr(2'd1, 32'h0000_0411);
        chk(tok[7:0] == 8'h55, "R3", "crc byte idx17", 64'(tok[7:0]), 64'h55);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);

        push(6'd41, 32'd0, 2'd1, 1'b0, "R4");
        wr(2'd1, 32'h0000_0769);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);

        // R8: forced stop while busy leaves busy alone
        push(6'd7, 32'd0, 2'd1, 1'b0, "R4");
        wr(2'd1, 32'h0000_0507);
        push(6'd12, 32'd0, 2'd1, 1'b0, "R8");
        wr(2'd2, 32'h0000_0001);
        chk(busy, "R8", "busy unchanged by stop", 64'(busy), 64'd1);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);

        // R9/R10: armed multi-block, 3 blocks
        wr(2'd2, 32'h0000_0100);
        chk(!tok_vld, "R9", "arm write no token", 64'(tok_vld), 64'd0);
        blk_count = 16'd3;
        wr(2'd0, 32'h0000_1000);
        push(6'd18, 32'h1000, 2'd1, 1'b0, "R10");
        wr(2'd1, 32'h0000_3C12);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        chk(!auto_stop, "R10", "early auto stop", 64'(auto_stop), 64'd0);
        push(6'd12, 32'd0, 2'd1, 1'b1, "R10");
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        chk(auto_stop, "R10", "auto stop after last block", 64'(auto_stop), 64'd1);
        idle();
        chk(!auto_stop, "R10", "auto stop single pulse", 64'(auto_stop), 64'd0);

        // R10: disarmed after firing, no second stop
        push(6'd18, 32'h1000, 2'd1, 1'b0, "R10");
        wr(2'd1, 32'h0000_3C12);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
            chk(!tok_vld && !auto_stop, "R10", "stop while disarmed", 64'(tok_vld), 64'd0);
        end

        // R11: single-block data command does not track
        wr(2'd2, 32'h0000_0100);
        push(6'd17, 32'h1000, 2'd1, 1'b0, "R11");
        wr(2'd1, 32'h0000_1C11);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        chk(!tok_vld, "R11", "block done untracked", 64'(tok_vld), 64'd0);

        // R8: forced stop cancels tracking (arm still held from above)
        blk_count = 16'd2;
        push(6'd18, 32'h1000, 2'd1, 1'b0, "R11");
        wr(2'd1, 32'h0000_3C12);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        push(6'd12, 32'd0, 2'd1, 1'b0, "R8");
        wr(2'd2, 32'h0000_0001);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        chk(!tok_vld && !auto_stop, "R8", "tracking cancelled", 64'(tok_vld), 64'd0);

        // R12: auto stop beats same-cycle command write
        wr(2'd2, 32'h0000_0100);
        blk_count = 16'd1;
        push(6'd18, 32'h1000, 2'd1, 1'b0, "R12");
        wr(2'd1, 32'h0000_3C12);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        push(6'd12, 32'd0, 2'd1, 1'b1, "R12");
        step(1'b1, 2'd1, 32'h0000_0408, 1'b1, 1'b0, 1'b0);
        chk(!busy, "R12", "command write dropped", 64'(busy), 64'd0);
        idle();
        chk(!tok_vld, "R12", "no late command token", 64'(tok_vld), 64'd0);

        // R12: stop-control write suppresses the final auto stop
        wr(2'd2, 32'h0000_0100);
        push(6'd18, 32'h1000, 2'd1, 1'b0, "R12");
        wr(2'd1, 32'h0000_3C12);
        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 2'd2, 32'h0000_0100, 1'b1, 1'b0, 1'b0);
        chk(!tok_vld && !auto_stop, "R12", "stop write wins", 64'(auto_stop), 64'd0);
        wr(2'd2, 32'h0000_0000);

        // R2/R4: sweep of indices, arguments and all response types
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            logic [5:0]  ix;
            logic [2:0]  t;
            a  = 32'h9E37_79B9 * (k + 1);
            ix = 6'((k * 7 + 3) % 64);
            t  = 3'((k + 3) % 8);
            wr(2'd0, a);
            push(ix, a, ref_kind(t), 1'b0, "R2");
            wr(2'd1, {16'd0, 5'd0, t, 2'b00, ix});
            chk(busy == (ref_kind(t) != 2'd0), "R5", "busy by type",
                64'(busy), 64'(ref_kind(t) != 2'd0));
            step(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        end

        repeat (3) idle();
        chk(exp_q.size() == 0, "R2", "tokens outstanding", 64'(exp_q.size()), 64'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule